// File: doc/BRIEF.md
# Serial Channel Error Flag Register

This block keeps the two sticky error flags of a serial channel that runs either as an asynchronous UART or as a clocked synchronous I/O interface. It watches single-cycle event strobes and level inputs from the receive path, the transmit path and the parity checker, and turns qualifying events into flags. It is not the shifter, the FIFOs or the bus interface. Software sees the flags through a status register, and reading that register clears them.

The overrun flag reports a received frame that arrived while there was nowhere to keep it. Without a receive FIFO, that means the single receive buffer still held unread data. With the FIFO on, it means the FIFO had reached its usable depth. The second flag has two meanings. In UART mode it reports a parity mismatch. In synchronous mode it reports a transmit under-run: the shift register finished, and at the next transfer clock neither the transmit double buffer nor, if enabled, the transmit FIFO had data to supply.

Every input is plain control. No data stream passes through the block, so there is no valid/ready interface and no back-pressure. The strobes are sampled on the rising clock edge, and the flags change one cycle later.

Top module: `sio_err_flags`

## Requirements
- R1: After reset both `overrun_flag` and `perr_flag` are 0.
- R2: With `rx_fifo_en`=0, the overrun flag sets at the edge after an `rx_frame_done` pulse, but only if an earlier frame is still unread. A frame is held from its `rx_frame_done` until an `rx_buf_read` pulse; a read in the same cycle as a new frame empties the buffer first. This applies in UART mode and in synchronous clock-input mode.
- R3: With `rx_fifo_en`=1, an `rx_frame_done` sets overrun only when `rx_fifo_count` is at least the usable depth. The usable depth is `rx_fifo_limit`, except that a value of 0 or a value above `FIFO_DEPTH` selects `FIFO_DEPTH`.
- R4: In UART mode (`sync_mode`=0) a `parity_err` pulse sets `perr_flag`. In synchronous mode `parity_err` is ignored.
- R5: Under-run is possible only when `sync_mode`=1, `clk_out_mode`=0 and `tx_dbuf_en`=1. In that case a `tx_shift_done` pulse arms a check. The first later `tx_xfer_clk` pulse disarms it, and sets `perr_flag` if `tx_dbuf_empty`=1 at that pulse and the transmit FIFO has no data to supply (see R6). A `tx_xfer_clk` with no `tx_shift_done` before it sets nothing.
- R6: With `tx_fifo_en`=1, under-run additionally requires `tx_fifo_empty`=1. With `tx_fifo_en`=0, `tx_fifo_empty` has no effect.
- R7: With `tx_dbuf_en`=0, under-run never sets.
- R8: In synchronous clock-output mode (`sync_mode`=1, `clk_out_mode`=1), both flags are 0 from the next cycle on, and no event sets them.
- R9: A `status_rd` pulse clears both flags at the next edge. If a set event for a flag arrives in the same cycle as the read, that flag is 1 after the edge.
- R10: Flags are sticky: once set, a flag stays 1 until a `status_rd` or clock-output mode clears it.
- R11: In UART mode the transmit-side under-run inputs never set `perr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 0 = UART, 1 = synchronous I/O interface |
| clk_out_mode | input | 1 | In synchronous mode, 1 = this side drives the transfer clock |
| tx_dbuf_en | input | 1 | Transmit double buffer enabled |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| tx_fifo_en | input | 1 | Transmit FIFO enabled |
| rx_fifo_limit | input | CNT_W | Usable receive FIFO depth (0 = full depth) |
| rx_fifo_count | input | CNT_W | Current receive FIFO occupancy |
| rx_frame_done | input | 1 | Pulse: a receive frame completed |
| rx_buf_read | input | 1 | Pulse: the receive buffer was read |
| parity_err | input | 1 | Pulse: the parity checker found a mismatch |
| tx_shift_done | input | 1 | Pulse: the transmit shift register finished |
| tx_xfer_clk | input | 1 | Pulse: the next transfer clock arrived |
| tx_dbuf_empty | input | 1 | Transmit double buffer holds no data |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| status_rd | input | 1 | Pulse: the status register was read |
| overrun_flag | output | 1 | Sticky overrun flag |
| perr_flag | output | 1 | Sticky parity / under-run flag |

## Verification
The receive side is swept over every FIFO occupancy from empty to full against every possible limit value. This shows whether the usable-depth comparison and the clamping of 0 and over-range limits are right. The transmit side is swept over all combinations of mode, clock direction, double-buffer enable, FIFO enable and the two emptiness levels. This separates the starvation condition from the gating by mode. The parity input is swept over mode and clock direction to show that one flag changes meaning with the mode. Directed sequences cover a read and a frame in the same cycle, a read colliding with a set event, stickiness over idle cycles, and the clearing that clock-output mode forces.

// File: rtl/sio_err_pkg.sv
package sio_err_pkg;

  localparam int unsigned FLAG_OVR  = 0;
  localparam int unsigned FLAG_PERR = 1;
  localparam int unsigned NUM_FLAGS = 2;

  typedef struct packed {
    logic sync_mode;
    logic clk_out;
    logic dbuf_en;
    logic rx_fifo_en;
    logic tx_fifo_en;
  } sio_cfg_t;

  // Error detection is suppressed when this side drives the synchronous clock.
  function automatic logic errors_allowed(sio_cfg_t c);
    return !(c.sync_mode && c.clk_out);
  endfunction

  function automatic logic underrun_allowed(sio_cfg_t c);
    return c.sync_mode && !c.clk_out && c.dbuf_en;
  endfunction

endpackage

// File: rtl/sio_rx_overrun.sv
module sio_rx_overrun
  import sio_err_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sio_cfg_t         cfg,
  input  logic             frame_done,
  input  logic             buf_read,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] fifo_limit,
  output logic             ovr_set
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  logic             held_q;
  logic [CNT_W-1:0] eff_limit;
  logic             fifo_at_limit;
  logic             buf_busy;

  always_comb begin
    if (fifo_limit == '0 || fifo_limit > DEPTH_C) eff_limit = DEPTH_C;
    else                                          eff_limit = fifo_limit;
  end

  assign fifo_at_limit = (fifo_count >= eff_limit);
  // A read in the same cycle frees the buffer before the new frame lands.
  assign buf_busy      = held_q && !buf_read;

  always_ff @(posedge clk) begin
    if (!rst_n)              held_q <= 1'b0;
    else if (cfg.rx_fifo_en) held_q <= 1'b0;
    else                     held_q <= buf_busy || frame_done;
  end

  assign ovr_set = errors_allowed(cfg) && frame_done &&
                   (cfg.rx_fifo_en ? fifo_at_limit : buf_busy);

endmodule

// File: rtl/sio_tx_underrun.sv
module sio_tx_underrun
  import sio_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sio_cfg_t cfg,
  input  logic     shift_done,
  input  logic     xfer_clk,
  input  logic     dbuf_empty,
  input  logic     fifo_empty,
  output logic     udr_set
);

  logic armed_q;
  logic enabled;
  logic starved;

  assign enabled = underrun_allowed(cfg);
  assign starved = dbuf_empty && (!cfg.tx_fifo_en || fifo_empty);

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (!enabled) armed_q <= 1'b0;
    else               armed_q <= shift_done || (armed_q && !xfer_clk);
  end

  assign udr_set = enabled && armed_q && xfer_clk && starved;

endmodule

// File: rtl/sio_sticky_flag.sv
module sio_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_clr,
  input  logic force_clr,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (force_clr) flag_q <= 1'b0;
    else if (set_evt)   flag_q <= 1'b1;
    else if (rd_clr)    flag_q <= 1'b0;
  end

endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags
  import sio_err_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             clk_out_mode,
  input  logic             tx_dbuf_en,
  input  logic             rx_fifo_en,
  input  logic             tx_fifo_en,
  input  logic [CNT_W-1:0] rx_fifo_limit,
  input  logic [CNT_W-1:0] rx_fifo_count,
  input  logic             rx_frame_done,
  input  logic             rx_buf_read,
  input  logic             parity_err,
  input  logic             tx_shift_done,
  input  logic             tx_xfer_clk,
  input  logic             tx_dbuf_empty,
  input  logic             tx_fifo_empty,
  input  logic             status_rd,
  output logic             overrun_flag,
  output logic             perr_flag
);

  sio_cfg_t             cfg;
  logic                 ovr_evt;
  logic                 udr_evt;
  logic                 par_evt;
  logic                 quiet;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;

  assign cfg = '{sync_mode:  sync_mode,
                 clk_out:    clk_out_mode,
                 dbuf_en:    tx_dbuf_en,
                 rx_fifo_en: rx_fifo_en,
                 tx_fifo_en: tx_fifo_en};

  sio_rx_overrun #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .frame_done (rx_frame_done),
    .buf_read   (rx_buf_read),
    .fifo_count (rx_fifo_count),
    .fifo_limit (rx_fifo_limit),
    .ovr_set    (ovr_evt)
  );

  sio_tx_underrun u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .shift_done (tx_shift_done),
    .xfer_clk   (tx_xfer_clk),
    .dbuf_empty (tx_dbuf_empty),
    .fifo_empty (tx_fifo_empty),
    .udr_set    (udr_evt)
  );

  assign par_evt = !sync_mode && parity_err;
  assign quiet   = !errors_allowed(cfg);

  assign set_vec[FLAG_OVR]  = ovr_evt;
  assign set_vec[FLAG_PERR] = udr_evt || par_evt;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sio_sticky_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_evt   (set_vec[g]),
      .rd_clr    (status_rd),
      .force_clr (quiet),
      .flag_q    (flag_vec[g])
    );
  end

  assign overrun_flag = flag_vec[FLAG_OVR];
  assign perr_flag    = flag_vec[FLAG_PERR];

endmodule

// File: rtl/sio_err_flags_chk.sv
module sio_err_flags_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             clk_out_mode,
  input logic             tx_dbuf_en,
  input logic             rx_fifo_en,
  input logic [CNT_W-1:0] rx_fifo_count,
  input logic             status_rd,
  input logic             ovr_evt,
  input logic             udr_evt,
  input logic             overrun_flag,
  input logic             perr_flag
);

  AST_CLKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && clk_out_mode) |=> (!overrun_flag && !perr_flag)); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovr_evt) |=> !overrun_flag); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun_flag); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_flag && !status_rd && !(sync_mode && clk_out_mode)) |=> overrun_flag); // R10

  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_en && rx_fifo_count == '0) |-> !ovr_evt); // R3

  AST_NO_DBUF_NO_UDR: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dbuf_en |-> !udr_evt); // R7

  AST_UART_NO_UDR: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !udr_evt); // R11

endmodule

bind sio_err_flags sio_err_flags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_mode     (sync_mode),
  .clk_out_mode  (clk_out_mode),
  .tx_dbuf_en    (tx_dbuf_en),
  .rx_fifo_en    (rx_fifo_en),
  .rx_fifo_count (rx_fifo_count),
  .status_rd     (status_rd),
  .ovr_evt       (ovr_evt),
  .udr_evt       (udr_evt),
  .overrun_flag  (overrun_flag),
  .perr_flag     (perr_flag)
);

// File: tb/sio_err_flags_bench.sv
module sio_err_flags_bench;

  localparam int unsigned DEPTH = 4;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic sync_mode, clk_out_mode, tx_dbuf_en, rx_fifo_en, tx_fifo_en;
  logic [CW-1:0] rx_fifo_limit, rx_fifo_count;
  logic rx_frame_done, rx_buf_read, parity_err;
  logic tx_shift_done, tx_xfer_clk, tx_dbuf_empty, tx_fifo_empty, status_rd;
  logic overrun_flag, perr_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sio_err_flags #(.FIFO_DEPTH(DEPTH)) u_sio_err_flags (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .clk_out_mode(clk_out_mode),
    .tx_dbuf_en(tx_dbuf_en), .rx_fifo_en(rx_fifo_en), .tx_fifo_en(tx_fifo_en),
    .rx_fifo_limit(rx_fifo_limit), .rx_fifo_count(rx_fifo_count),
    .rx_frame_done(rx_frame_done), .rx_buf_read(rx_buf_read), .parity_err(parity_err),
    .tx_shift_done(tx_shift_done), .tx_xfer_clk(tx_xfer_clk),
    .tx_dbuf_empty(tx_dbuf_empty), .tx_fifo_empty(tx_fifo_empty),
    .status_rd(status_rd), .overrun_flag(overrun_flag), .perr_flag(perr_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    rx_frame_done = 0; rx_buf_read = 0; parity_err = 0;
    tx_shift_done = 0; tx_xfer_clk = 0; status_rd = 0;
  endtask

  task automatic read_status();
    status_rd = 1; tick(); status_rd = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_mode = 0; clk_out_mode = 0; tx_dbuf_en = 0;
    rx_fifo_en = 0; tx_fifo_en = 0; rx_fifo_limit = '0; rx_fifo_count = '0;
    tx_dbuf_empty = 0; tx_fifo_empty = 0;
    clear_strobes();
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 overrun after reset", overrun_flag, 1'b0);
    chk("R1 perr after reset", perr_flag, 1'b0);

    // R2: no FIFO, UART then synchronous clock-input
    for (int m = 0; m < 2; m++) begin
      sync_mode = logic'(m);
      rx_buf_read = 1; tick(); rx_buf_read = 0;
      read_status();
      rx_frame_done = 1; tick(); rx_frame_done = 0;
      chk("R2 first frame into empty buffer", overrun_flag, 1'b0);
      rx_buf_read = 1; rx_frame_done = 1; tick(); clear_strobes();
      chk("R2 read with frame same cycle", overrun_flag, 1'b0);
      rx_frame_done = 1; tick(); rx_frame_done = 0;
      chk("R2 frame onto unread buffer", overrun_flag, 1'b1);
      // R10: sticky over idle cycles
      repeat (5) tick();
      chk("R10 overrun stays set", overrun_flag, 1'b1);
      // R9: set wins against read
      rx_frame_done = 1; status_rd = 1; tick(); clear_strobes();
      chk("R9 set wins over read", overrun_flag, 1'b1);
      read_status();
      chk("R9 read clears overrun", overrun_flag, 1'b0);
    end
    sync_mode = 0;

    // R3: FIFO occupancy versus every limit value
    rx_fifo_en = 1;
    for (int lim = 0; lim < (1 << CW); lim++) begin
      for (int cnt = 0; cnt <= DEPTH; cnt++) begin
        int eff;
        eff = (lim == 0 || lim > DEPTH) ? DEPTH : lim;
        rx_fifo_limit = CW'(lim); rx_fifo_count = CW'(cnt);
        rx_frame_done = 1; tick(); rx_frame_done = 0;
        chk($sformatf("R3 fifo cnt=%0d lim=%0d", cnt, lim), overrun_flag, logic'(cnt >= eff));
        read_status();
      end
    end
    rx_fifo_en = 0; rx_fifo_count = '0; rx_fifo_limit = '0;

    // R4: parity across mode and clock direction
    for (int v = 0; v < 4; v++) begin
      sync_mode = logic'(v >> 1); clk_out_mode = logic'(v & 1);
      tick(); read_status();
      parity_err = 1; tick(); parity_err = 0;
      chk($sformatf("R4 parity sync=%0d clkout=%0d", v >> 1, v & 1), perr_flag, logic'((v >> 1) == 0));
    end
    sync_mode = 0; clk_out_mode = 0;
    read_status();

    // R5 R6 R7 R11 R8: full transmit-side sweep
    for (int v = 0; v < 64; v++) begin
      logic s, co, de, fe, be, ffe, exp;
      {s, co, de, fe, be, ffe} = 6'(v);
      sync_mode = s; clk_out_mode = co; tx_dbuf_en = de; tx_fifo_en = fe;
      tx_dbuf_empty = be; tx_fifo_empty = ffe;
      read_status();
      tx_shift_done = 1; tick(); tx_shift_done = 0;
      tx_xfer_clk = 1; tick(); tx_xfer_clk = 0;
      exp = s && !co && de && be && (!fe || ffe);
      chk($sformatf("R5 R6 R7 R11 underrun s=%0d co=%0d de=%0d fe=%0d be=%0d ffe=%0d",
                    s, co, de, fe, be, ffe), perr_flag, exp);
    end

    // R5: transfer clock without prior shift completion
    sync_mode = 1; clk_out_mode = 0; tx_dbuf_en = 1; tx_fifo_en = 0; tx_dbuf_empty = 1;
    read_status();
    tx_xfer_clk = 1; tick(); tx_xfer_clk = 0;
    chk("R5 xfer clock without shift done", perr_flag, 1'b0);

    // R8: clock-output mode clears and blocks
    sync_mode = 0; clk_out_mode = 0; rx_buf_read = 1; tick(); rx_buf_read = 0;
    rx_frame_done = 1; tick(); tick(); rx_frame_done = 0;
    parity_err = 1; tick(); parity_err = 0;
    chk("R8 precondition overrun", overrun_flag, 1'b1);
    chk("R8 precondition perr", perr_flag, 1'b1);
    sync_mode = 1; clk_out_mode = 1; tick();
    chk("R8 clock-output clears overrun", overrun_flag, 1'b0);
    chk("R8 clock-output clears perr", perr_flag, 1'b0);
    rx_frame_done = 1; tick(); tick(); rx_frame_done = 0;
    chk("R8 no overrun in clock-output", overrun_flag, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule